// File: doc/BRIEF.md
# Bus Bit-Time Stamp Counter

This block keeps a free-running time base measured in bus bit times rather than clock cycles. A bit-time strobe from the bit-timing logic advances a 16-bit count by one. When the frame decoder enters the acknowledge slot, the block latches the count and the index of the message buffer taking part in the transfer. If the frame then completes without error, the latched value is delivered on a one-cycle write port. That port carries the buffer index and the stamp, and the buffer memory stores the stamp as the time-stamp word of that buffer.

Transfers through buffer 0 can also act as a network time reference. When a single global enable is set, a successful buffer-0 transfer clears the count to zero in the same cycle its stamp is written out. Every node that sees the same frame then restarts its time base from a common point. With the enable clear, buffer 0 is stamped like any other buffer and the count keeps running. A frame that fails throws its latched sample away, so it never produces a write. Bit timing and frame decoding sit outside this block.

Top module: `bit_stamp_ctr`

## Requirements
- R1: The counter `cnt_o` rises by exactly one on each clock edge where `bit_tick` is 1, and holds its value on edges where `bit_tick` is 0.
- R2: The counter wraps from 16'hFFFF to 16'h0000 on the next strobe. No flag or other output changes because of the wrap.
- R3: On the first cycle of an `ack_slot` high period, the block samples the counter value present in that cycle, before any increment from a strobe in the same cycle. It also samples `buf_idx` in that cycle. Later cycles of the same slot do not change the sample, and neither do later changes of `buf_idx`.
- R4: A cycle with `frame_done`=1 and `frame_ok`=1 that follows a sample produces `cap_we`=1 for exactly one cycle, starting on the next cycle. In that cycle `cap_idx` is the sampled index and `cap_val` is the sampled count.
- R5: A cycle with `frame_done`=1 and `frame_ok`=0 produces no write and discards the sample. A later `frame_done`=1 with `frame_ok`=1 and no new acknowledge slot in between also produces no write.
- R6: A successful end of frame whose sampled index is 0, with `sync_en`=1 in the `frame_done` cycle, leaves `cnt_o` at 0 in the same cycle that `cap_we` rises.
- R7: With `sync_en`=0, or with a sampled index other than 0, a successful end of frame leaves the counter running as in R1.
- R8: When a strobe and the synchronisation clear of R6 fall on the same edge, the clear wins and the counter is 0.
- R9: While `rst` is 1 at a clock edge, the counter goes to 0, `cap_we` goes to 0 and any held sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per recognised bus bit time |
| ack_slot | input | 1 | High while the frame is in its acknowledge slot |
| frame_done | input | 1 | One-cycle end-of-frame strobe |
| frame_ok | input | 1 | Qualifies `frame_done`: 1 means the transfer succeeded |
| buf_idx | input | 4 | Index of the message buffer active in the current frame |
| sync_en | input | 1 | Global enable for buffer-0 network synchronisation |
| cnt_o | output | 16 | Live counter value |
| cap_we | output | 1 | Write strobe for a time-stamp word |
| cap_idx | output | 4 | Buffer index for the time-stamp write |
| cap_val | output | 16 | Stamp value to write |

## Verification
The bench sweeps every buffer index against both outcomes and both synchronisation settings, and compares each case with arithmetic expectations. A strobe lands in the first acknowledge cycle, so a design that sampled after the increment, or resampled through the whole slot, would write a stamp one or two counts too high. `buf_idx` changes after the slot, so a design that read the index late would write to the wrong buffer. A failed frame is followed by a bare successful end-of-frame, which catches a design that keeps a stale sample alive. Strobing in the clearing cycle catches a design that lets the increment beat the clear. The wrap from FFFF and a reset between the acknowledge slot and the end of frame are each checked at the ports.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TSC_CNT_W = 16;
  localparam int TSC_NBUF  = 15;

  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tsc_count.sv
module tsc_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  // clear has priority over advance; natural wrap at 2**W
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/tsc_ack_hold.sv
module tsc_ack_hold #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_slot,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] idx,
  output logic             held_vld,
  output logic [CNT_W-1:0] held_val,
  output logic [IDX_W-1:0] held_idx
);
  logic ack_q;
  logic ack_first;

  assign ack_first = ack_slot & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      held_vld <= 1'b0;
      held_val <= '0;
      held_idx <= '0;
    end else begin
      ack_q <= ack_slot;
      if (ack_first) begin
        held_vld <= 1'b1;
        held_val <= cnt;
        held_idx <= idx;
      end else if (frame_done) begin
        held_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 4,
  parameter int SYNC_IDX = 0,
  parameter bit SYNC_ON  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic             frame_ok,
  input  logic             sync_en,
  input  logic             held_vld,
  input  logic [CNT_W-1:0] held_val,
  input  logic [IDX_W-1:0] held_idx,
  output logic             sync_clr,
  output logic             cap_we,
  output logic [IDX_W-1:0] cap_idx,
  output logic [CNT_W-1:0] cap_val
);
  logic commit;

  assign commit = frame_done & frame_ok & held_vld;

  generate
    if (SYNC_ON) begin : g_sync
      assign sync_clr = commit & sync_en & (held_idx == IDX_W'(SYNC_IDX));
    end else begin : g_nosync
      assign sync_clr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_we  <= 1'b0;
      cap_idx <= '0;
      cap_val <= '0;
    end else begin
      cap_we <= commit;
      if (commit) begin
        cap_idx <= held_idx;
        cap_val <= held_val;
      end
    end
  end
endmodule

// File: rtl/bit_stamp_ctr.sv
module bit_stamp_ctr #(
  parameter int CNT_W    = tsc_pkg::TSC_CNT_W,
  parameter int NBUF     = tsc_pkg::TSC_NBUF,
  parameter int SYNC_IDX = 0,
  parameter bit SYNC_ON  = 1'b1,
  localparam int IDX_W   = tsc_pkg::idx_width(NBUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             ack_slot,
  input  logic             frame_done,
  input  logic             frame_ok,
  input  logic [IDX_W-1:0] buf_idx,
  input  logic             sync_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cap_we,
  output logic [IDX_W-1:0] cap_idx,
  output logic [CNT_W-1:0] cap_val
);
  logic             sync_clr;
  logic             held_vld;
  logic [CNT_W-1:0] held_val;
  logic [IDX_W-1:0] held_idx;

  tsc_count #(.W(CNT_W)) u_count (
    .clk (clk),
    .rst (rst),
    .adv (bit_tick),
    .clr (sync_clr),
    .cnt (cnt_o)
  );

  tsc_ack_hold #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .ack_slot   (ack_slot),
    .frame_done (frame_done),
    .cnt        (cnt_o),
    .idx        (buf_idx),
    .held_vld   (held_vld),
    .held_val   (held_val),
    .held_idx   (held_idx)
  );

  tsc_capture #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .SYNC_IDX(SYNC_IDX), .SYNC_ON(SYNC_ON)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .frame_ok   (frame_ok),
    .sync_en    (sync_en),
    .held_vld   (held_vld),
    .held_val   (held_val),
    .held_idx   (held_idx),
    .sync_clr   (sync_clr),
    .cap_we     (cap_we),
    .cap_idx    (cap_idx),
    .cap_val    (cap_val)
  );
endmodule

// File: rtl/bit_stamp_ctr_chk.sv
module bit_stamp_ctr_chk #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             frame_done,
  input logic             frame_ok,
  input logic             sync_clr,
  input logic [CNT_W-1:0] cnt_o,
  input logic             cap_we,
  input logic [IDX_W-1:0] cap_idx
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !sync_clr) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !sync_clr) |=> $stable(cnt_o)); // R1
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> (cnt_o == '0 && cap_we && cap_idx == '0)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (sync_clr && bit_tick) |=> cnt_o == '0); // R8
  AST_WRITE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cap_we |-> $past(frame_done && frame_ok)); // R4
  AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_ok) |=> !cap_we); // R5
endmodule

bind bit_stamp_ctr bit_stamp_ctr_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_tick   (bit_tick),
  .frame_done (frame_done),
  .frame_ok   (frame_ok),
  .sync_clr   (sync_clr),
  .cnt_o      (cnt_o),
  .cap_we     (cap_we),
  .cap_idx    (cap_idx)
);

// File: tb/bit_stamp_ctr_tb.sv
`timescale 1ns/1ps
module bit_stamp_ctr_tb;
  localparam int CW = 16;
  localparam int NB = 15;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          bit_tick = 1'b0, ack_slot = 1'b0, frame_done = 1'b0, frame_ok = 1'b0;
  logic [IW-1:0] buf_idx = '0;
  logic          sync_en = 1'b0;
  logic [CW-1:0] cnt_o, cap_val;
  logic          cap_we;
  logic [IW-1:0] cap_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [CW-1:0] exp_cnt = '0;

  bit_stamp_ctr u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .ack_slot(ack_slot),
    .frame_done(frame_done), .frame_ok(frame_ok), .buf_idx(buf_idx),
    .sync_en(sync_en), .cnt_o(cnt_o), .cap_we(cap_we), .cap_idx(cap_idx),
    .cap_val(cap_val)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n, input bit each);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      exp_cnt = exp_cnt + 16'd1;
      if (each) chk(cnt_o == exp_cnt, "R1 step", cnt_o, exp_cnt);
    end
    bit_tick = 1'b0;
  endtask

  task automatic frame(input int idx, input bit ok, input bit sen, input int pre);
    logic [CW-1:0] held;
    bit clr;
    ticks(pre, 1'b0);
    held = exp_cnt;
    buf_idx = IW'(idx); ack_slot = 1'b1; bit_tick = 1'b1;
    @(negedge clk); exp_cnt++;
    @(negedge clk); exp_cnt++;                  // second ack cycle, strobe again
    ack_slot = 1'b0; buf_idx = IW'(idx) ^ IW'(1);  // index moves after the slot
    @(negedge clk); exp_cnt++;
    frame_done = 1'b1; frame_ok = ok; sync_en = sen; bit_tick = 1'b1;
    @(negedge clk);
    clr = ok && sen && (idx == 0);
    exp_cnt = clr ? 16'd0 : exp_cnt + 16'd1;
    chk(cap_we == ok, ok ? "R4 write" : "R5 no write", cap_we, ok);
    if (ok) begin
      chk(cap_idx == IW'(idx), "R3 index", cap_idx, idx);
      chk(cap_val == held, "R3 stamp", cap_val, held);
    end
    chk(cnt_o == exp_cnt, clr ? "R6 R8 sync clear" : "R7 running", cnt_o, exp_cnt);
    frame_done = 1'b0; frame_ok = 1'b0; sync_en = 1'b0; bit_tick = 1'b0;
    @(negedge clk);
    chk(cap_we == 1'b0, "R4 single pulse", cap_we, 0);
    chk(cnt_o == exp_cnt, "R1 hold", cnt_o, exp_cnt);
    if (!ok) begin
      frame_done = 1'b1; frame_ok = 1'b1;
      @(negedge clk);
      chk(cap_we == 1'b0, "R5 stale sample", cap_we, 0);
      frame_done = 1'b0; frame_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnt_o == '0, "R9 reset count", cnt_o, 0);
    chk(cap_we == 1'b0, "R9 reset write", cap_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cnt_o == '0, "R1 idle", cnt_o, 0);
    ticks(5, 1'b1);
    @(negedge clk); @(negedge clk);
    chk(cnt_o == exp_cnt, "R1 hold gap", cnt_o, exp_cnt);
    ticks(3, 1'b1);

    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int b = 0; b < NB; b++)
          frame(b, o[0], s[0], (b % 3) + 1);

    // wrap: synchronise to zero first, then run up to the top
    frame(0, 1'b1, 1'b1, 2);
    ticks(65535, 1'b0);
    chk(cnt_o == 16'hFFFF, "R2 top", cnt_o, 16'hFFFF);
    ticks(1, 1'b0);
    chk(cnt_o == 16'h0000, "R2 wrap", cnt_o, 0);
    chk(cap_we == 1'b0, "R2 no flag", cap_we, 0);

    // reset between acknowledge slot and end of frame
    ack_slot = 1'b1; buf_idx = 4'd3;
    @(negedge clk);
    ack_slot = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(cnt_o == '0, "R9 mid-frame reset", cnt_o, 0);
    rst = 1'b0; exp_cnt = '0;
    frame_done = 1'b1; frame_ok = 1'b1;
    @(negedge clk);
    chk(cap_we == 1'b0, "R9 sample dropped", cap_we, 0);
    frame_done = 1'b0; frame_ok = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule